// File: doc/BRIEF.md
# Critical-Word-First Line Fill Stage

This block runs the refill of one data-cache line after a miss. A miss request carries the physical line address, the double-word the load asked for, and the way chosen for the new line. The block then takes four 64-bit beats from the bus. The first beat is the requested double word, and the rest follow in wrap-around order. The first beat goes straight back to the load unit in the cycle it arrives, so the load does not wait for the rest of the line.

Each beat is copied into its own 8-byte slot of a 256-bit staging buffer. Once all four beats are in, the whole line is written into the cache array in a single cycle. During that cycle load/store access is held off, and the line is installed as Exclusive. One cycle later a done pulse is raised. If the bus reports an error on any beat, the fill is dropped, nothing is written to the array, and an error response goes to the requester.

The beat count (four) and the beat width (64 bits) are fixed package constants. The line address width and the way index width are module parameters.

Top module: `line_fill_stage`

## Requirements
- R1: After reset, `busy`, `fwdValid`, `fwdErr`, `arrWrEn`, `lsuHold` and `lineDone` are all low.
- R2: A request (`reqValid` high while `busy` is low) is accepted at the clock edge. `busy` is high from the next cycle through the array-write cycle, and low in the cycle after it. A request raised while `busy` is high is ignored and does not change the address or way that is written.
- R3: In the cycle the first good beat of a fill is presented, `fwdValid` is high and `fwdData` equals `busData`. `fwdValid` is low on every other beat.
- R4: With critical index c, beat k (k = 0..3, in arrival order) holds double word (c+k) mod 4. It is stored in `arrData[64*((c+k) mod 4)+63 : 64*((c+k) mod 4)]`.
- R5: `arrWrEn` is high for exactly one cycle: the cycle after the fourth good beat is captured. In that cycle `arrLineAddr` and `arrWay` equal the accepted request's line address and way.
- R6: During the array write, `arrState` is Exclusive, encoded 2'b10. Modified is 2'b11 and Invalid is 2'b00.
- R7: A cycle with `busValid` low leaves the fill unchanged. No beat is counted, nothing is forwarded, and the written line is the same as for a burst with no gaps.
- R8: A beat with `busValid` and `busErr` both high abandons the fill. In that cycle `fwdErr` is high and `fwdValid` is low. No array write follows, and `busy` is low in the next cycle.
- R9: `lsuHold` is high exactly in the array-write cycle, and `lineDone` pulses for one cycle in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Miss request strobe |
| reqLineAddr | input | ADDR_W | Physical line address of the miss |
| reqDwIdx | input | 2 | Index of the requested (critical) double word |
| reqWay | input | WAY_W | Way that receives the line |
| busy | output | 1 | Fill in progress |
| busValid | input | 1 | Bus beat data valid |
| busErr | input | 1 | Bus error flag for the current beat |
| busData | input | 64 | Bus beat data |
| fwdValid | output | 1 | Critical double word is on `fwdData` |
| fwdErr | output | 1 | Error response to the requester |
| fwdData | output | 64 | Forwarded double word |
| arrWrEn | output | 1 | One-cycle full-line array write |
| arrLineAddr | output | ADDR_W | Line address of the array write |
| arrWay | output | WAY_W | Way of the array write |
| arrState | output | 2 | Coherency state installed with the line |
| arrData | output | 256 | Full line for the array write |
| lsuHold | output | 1 | Load/store array access held off this cycle |
| lineDone | output | 1 | Line write completed |

## Verification
The hardest case to reach is the one where slot placement, stalls, a competing request and a late bus error all fall inside a single fill. A slip in any of them only shows up as wrong bytes in a line written several cycles later, or as a write that should never have happened. The bench walks a table of fills covering every critical index, with gap masks that insert idle bus cycles between chosen beats. Individual fills add a second request partway through, and bus errors on the first or the third beat. After each error fill, a clean fill checks that nothing stale leaks into the next line.

// File: rtl/line_fill_pkg.sv
package line_fill_pkg;
  localparam int BEAT_W      = 64;
  localparam int LINE_BEATS  = 4;
  localparam int BEAT_IDX_W  = $clog2(LINE_BEATS);
  localparam int LINE_W      = BEAT_W * LINE_BEATS;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FILL   = 2'd1,
    ST_COMMIT = 2'd2
  } fillState_t;

  typedef enum logic [1:0] {
    COH_INV  = 2'b00,
    COH_EXCL = 2'b10,
    COH_MOD  = 2'b11
  } cohState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic                  latchReq;
    logic                  loadBeat;
    logic [BEAT_IDX_W-1:0] beatNum;
  } fillStrobe_t;
endpackage

// File: rtl/line_fill_ctrl.sv
module line_fill_ctrl
  import line_fill_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        busValid,
  input  logic        busErr,
  output fillStrobe_t strobes,
  output logic        busy,
  output logic        fwdValid,
  output logic        fwdErr,
  output logic        arrWrEn,
  output logic        lsuHold,
  output logic        lineDone
);
  localparam logic [BEAT_IDX_W-1:0] LAST_BEAT = BEAT_IDX_W'(LINE_BEATS - 1);

  fillState_t            state;
  logic [BEAT_IDX_W-1:0] beatCnt;
  logic                  doneQ;
  logic                  goodBeat;
  logic                  badBeat;

  assign goodBeat = (state == ST_FILL) && busValid && !busErr;
  assign badBeat  = (state == ST_FILL) && busValid && busErr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      beatCnt <= '0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= (state == ST_COMMIT);
      case (state)
        ST_IDLE: begin
          if (reqValid) begin
            state   <= ST_FILL;
            beatCnt <= '0;
          end
        end
        ST_FILL: begin
          if (badBeat) begin
            state <= ST_IDLE;
          end else if (goodBeat) begin
            beatCnt <= beatCnt + 1'b1;
            if (beatCnt == LAST_BEAT) state <= ST_COMMIT;
          end
        end
        ST_COMMIT: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.latchReq = (state == ST_IDLE) && reqValid;
    strobes.loadBeat = goodBeat;
    strobes.beatNum  = beatCnt;
  end

  assign busy     = (state != ST_IDLE);
  assign fwdValid = goodBeat && (beatCnt == '0);
  assign fwdErr   = badBeat;
  assign arrWrEn  = (state == ST_COMMIT);
  assign lsuHold  = arrWrEn;
  assign lineDone = doneQ;
endmodule

// File: rtl/line_fill_dpath.sv
module line_fill_dpath
  import line_fill_pkg::*;
#(
  parameter int ADDR_W = 27,
  parameter int WAY_W  = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  fillStrobe_t           strobes,
  input  logic [ADDR_W-1:0]     reqLineAddr,
  input  logic [BEAT_IDX_W-1:0] reqDwIdx,
  input  logic [WAY_W-1:0]      reqWay,
  input  logic [BEAT_W-1:0]     busData,
  output logic [ADDR_W-1:0]     arrLineAddr,
  output logic [WAY_W-1:0]      arrWay,
  output logic [LINE_W-1:0]     arrData
);
  logic [ADDR_W-1:0]     lineAddrQ;
  logic [WAY_W-1:0]      wayQ;
  logic [BEAT_IDX_W-1:0] critQ;
  logic [BEAT_IDX_W-1:0] slotSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineAddrQ <= '0;
      wayQ      <= '0;
      critQ     <= '0;
    end else if (strobes.latchReq) begin
      lineAddrQ <= reqLineAddr;
      wayQ      <= reqWay;
      critQ     <= reqDwIdx;
    end
  end

  // wrap-around slot: modulo by index width
  assign slotSel = critQ + strobes.beatNum;

  for (genvar s = 0; s < LINE_BEATS; s++) begin : g_slot
    logic [BEAT_W-1:0] slotQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotQ <= '0;
      end else if (strobes.loadBeat && (slotSel == BEAT_IDX_W'(s))) begin
        slotQ <= busData;
      end
    end
    assign arrData[s*BEAT_W +: BEAT_W] = slotQ;
  end

  assign arrLineAddr = lineAddrQ;
  assign arrWay      = wayQ;
endmodule

// File: rtl/line_fill_stage.sv
module line_fill_stage
  import line_fill_pkg::*;
#(
  parameter int ADDR_W = 27,
  parameter int WAY_W  = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [ADDR_W-1:0]     reqLineAddr,
  input  logic [BEAT_IDX_W-1:0] reqDwIdx,
  input  logic [WAY_W-1:0]      reqWay,
  output logic                  busy,
  input  logic                  busValid,
  input  logic                  busErr,
  input  logic [BEAT_W-1:0]     busData,
  output logic                  fwdValid,
  output logic                  fwdErr,
  output logic [BEAT_W-1:0]     fwdData,
  output logic                  arrWrEn,
  output logic [ADDR_W-1:0]     arrLineAddr,
  output logic [WAY_W-1:0]      arrWay,
  output logic [1:0]            arrState,
  output logic [LINE_W-1:0]     arrData,
  output logic                  lsuHold,
  output logic                  lineDone
);
  fillStrobe_t strobes;

  line_fill_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .busValid (busValid),
    .busErr   (busErr),
    .strobes  (strobes),
    .busy     (busy),
    .fwdValid (fwdValid),
    .fwdErr   (fwdErr),
    .arrWrEn  (arrWrEn),
    .lsuHold  (lsuHold),
    .lineDone (lineDone)
  );

  line_fill_dpath #(.ADDR_W(ADDR_W), .WAY_W(WAY_W)) dpath_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .reqLineAddr (reqLineAddr),
    .reqDwIdx    (reqDwIdx),
    .reqWay      (reqWay),
    .busData     (busData),
    .arrLineAddr (arrLineAddr),
    .arrWay      (arrWay),
    .arrData     (arrData)
  );

  assign fwdData  = busData;
  assign arrState = COH_EXCL;
endmodule

// File: rtl/line_fill_chk.sv
module line_fill_chk (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       busy,
  input logic       busValid,
  input logic       busErr,
  input logic       fwdValid,
  input logic       fwdErr,
  input logic       arrWrEn,
  input logic [1:0] arrState,
  input logic       lsuHold,
  input logic       lineDone
);
  logic [2:0] goodCnt;

  always_ff @(posedge clk) begin
    if (!rstN) goodCnt <= '0;
    else if (fwdErr || arrWrEn) goodCnt <= '0;
    else if (busy && busValid && !busErr) goodCnt <= goodCnt + 1'b1;
  end

  p_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid) |=> busy);

  p_fwd_in_fill_r3: assert property (@(posedge clk) disable iff (!rstN)
    fwdValid |-> (busy && !arrWrEn && !fwdErr));

  p_full_line_r4: assert property (@(posedge clk) disable iff (!rstN)
    arrWrEn |-> (goodCnt == 3'd4));

  p_single_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    arrWrEn |=> !arrWrEn);

  p_excl_state_r6: assert property (@(posedge clk) disable iff (!rstN)
    arrWrEn |-> (arrState == 2'b10));

  p_stall_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |-> (!fwdValid && !fwdErr));

  p_err_no_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    fwdErr |=> (!arrWrEn && !busy));

  p_done_after_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    arrWrEn |=> (lineDone && !lsuHold));
endmodule

bind line_fill_stage line_fill_chk chk_i (.*);

// File: tb/line_fill_stage_tb_top.sv
`timescale 1ns/100ps
module line_fill_stage_tb_top;
  localparam int ADDR_W = 27;
  localparam int WAY_W  = 3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic [ADDR_W-1:0] reqLineAddr = '0;
  logic [1:0]        reqDwIdx = '0;
  logic [WAY_W-1:0]  reqWay = '0;
  logic              busy;
  logic              busValid = 1'b0;
  logic              busErr = 1'b0;
  logic [63:0]       busData = '0;
  logic              fwdValid, fwdErr;
  logic [63:0]       fwdData;
  logic              arrWrEn;
  logic [ADDR_W-1:0] arrLineAddr;
  logic [WAY_W-1:0]  arrWay;
  logic [1:0]        arrState;
  logic [255:0]      arrData;
  logic              lsuHold, lineDone;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  line_fill_stage #(.ADDR_W(ADDR_W), .WAY_W(WAY_W)) dut_i (.*);

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [1:0]        crit;
    logic [WAY_W-1:0]  way;
    logic [3:0]        gaps;
    logic [7:0]        seed;
  } fillVec_t;

  localparam fillVec_t VECS [6] = '{
    '{27'h0000123, 2'd0, 3'd0, 4'b0000, 8'd1},
    '{27'h7FFFFFF, 2'd1, 3'd7, 4'b0000, 8'd2},
    '{27'h1234567, 2'd2, 3'd3, 4'b0010, 8'd3},
    '{27'h0ABCDEF, 2'd3, 3'd5, 4'b1010, 8'd4},
    '{27'h5555555, 2'd1, 3'd2, 4'b0100, 8'd5},
    '{27'h2AAAAAA, 2'd2, 3'd6, 4'b1000, 8'd6}
  };

  function automatic logic [63:0] beatData(input logic [7:0] seed, input int dw);
    return {16'hD000 + 16'(seed), 16'(dw), 32'hFACE_0000 + 32'(int'(seed) * 4 + dw)};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // errBeat < 0 means no error; busyReq raises a competing request on beat 1
  task automatic runFill(input logic [ADDR_W-1:0] addr, input logic [1:0] crit,
                         input logic [WAY_W-1:0] way, input logic [3:0] gaps,
                         input logic [7:0] seed, input int errBeat, input bit busyReq);
    logic [255:0] expLine;
    @(negedge clk);
    reqValid = 1'b1; reqLineAddr = addr; reqDwIdx = crit; reqWay = way;
    @(negedge clk);
    reqValid = 1'b0;
    #1 chk("R2", "busy after accept", 256'(busy), 256'(1));
    for (int k = 0; k < 4; k++) begin
      int dw;
      dw = (int'(crit) + k) % 4;
      if (gaps[k]) begin
        @(negedge clk);
        busValid = 1'b0;
        #1 chk("R7", "no forward while stalled", 256'({fwdValid, fwdErr, arrWrEn}), 256'(0));
      end
      @(negedge clk);
      busValid = 1'b1; busData = beatData(seed, dw); busErr = (k == errBeat);
      if (busyReq && k == 1) begin
        reqValid = 1'b1; reqLineAddr = ~addr; reqWay = ~way; reqDwIdx = crit + 2'd1;
      end else begin
        reqValid = 1'b0;
      end
      #1;
      if (k == errBeat) begin
        chk("R8", "fwdErr on error beat", 256'({fwdErr, fwdValid}), 256'(2'b10));
        @(negedge clk);
        busValid = 1'b0; busErr = 1'b0;
        #1 chk("R8", "abandoned, no write", 256'({busy, arrWrEn}), 256'(0));
        @(negedge clk);
        #1 chk("R8", "no late write", 256'({arrWrEn, lineDone}), 256'(0));
        return;
      end
      if (k == 0) begin
        chk("R3", "critical forwarded", 256'(fwdValid), 256'(1));
        chk("R3", "critical data", 256'(fwdData), 256'(beatData(seed, dw)));
      end else begin
        chk("R3", "no forward on later beat", 256'(fwdValid), 256'(0));
      end
    end
    @(negedge clk);
    busValid = 1'b0; reqValid = 1'b0;
    for (int j = 0; j < 4; j++) expLine[j*64 +: 64] = beatData(seed, j);
    #1;
    chk("R5", "write strobe", 256'(arrWrEn), 256'(1));
    chk("R5", "write address", 256'(arrLineAddr), 256'(addr));
    chk("R5", "write way", 256'(arrWay), 256'(way));
    chk("R4", "line slot placement", arrData, expLine);
    chk("R6", "exclusive state", 256'(arrState), 256'(2'b10));
    chk("R9", "lsu held during write", 256'(lsuHold), 256'(1));
    chk("R2", "busy through write", 256'(busy), 256'(1));
    @(negedge clk);
    #1;
    chk("R9", "done pulse", 256'(lineDone), 256'(1));
    chk("R5", "single write cycle", 256'({arrWrEn, lsuHold}), 256'(0));
    chk("R2", "idle after write", 256'(busy), 256'(0));
    @(negedge clk);
    #1 chk("R9", "done is one cycle", 256'(lineDone), 256'(0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1 chk("R1", "reset outputs",
           256'({busy, fwdValid, fwdErr, arrWrEn, lsuHold, lineDone}), 256'(0));

    // table walk
    for (int v = 0; v < 6; v++) begin
      runFill(VECS[v].addr, VECS[v].crit, VECS[v].way, VECS[v].gaps, VECS[v].seed, -1, 1'b0);
    end

    // R2: a request during a fill is ignored
    runFill(27'h0F0F0F0, 2'd3, 3'd1, 4'b0001, 8'd20, -1, 1'b1);

    // R8: error on critical beat, then a clean fill
    runFill(27'h1111111, 2'd1, 3'd4, 4'b0000, 8'd30, 0, 1'b0);
    runFill(27'h2222222, 2'd0, 3'd2, 4'b0000, 8'd31, -1, 1'b0);

    // R8: error after forward (third beat), then a clean fill
    runFill(27'h3333333, 2'd2, 3'd5, 4'b0100, 8'd40, 2, 1'b0);
    runFill(27'h4444444, 2'd3, 3'd6, 4'b0000, 8'd41, -1, 1'b0);

    // R7: bus strobes while idle start nothing
    @(negedge clk);
    busValid = 1'b1; busData = 64'hDEAD;
    #1 chk("R7", "idle beat ignored", 256'({fwdValid, fwdErr, busy}), 256'(0));
    @(negedge clk);
    busValid = 1'b0;
    #1 chk("R7", "no write from idle beat", 256'({arrWrEn, busy}), 256'(0));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule